// File: doc/BRIEF.md
# Routing Result Dispatcher with Internal Shim Generator

This block sits after the route lookup stage of a virtual-router data path. For each packet it takes the lookup outcome and the flags that go with it, the exception bits raised by the header parser, and the interface identifiers. It then picks one of four fates for the packet:

- fast path to the egress line card;
- forwarding to a regular processing engine;
- diversion to the control engine;
- discard.

Alongside that decision it emits the queue and port the packet must be enqueued on. A numeric type code says why this fate was chosen.

Whenever the packet leaves toward an engine, the block also produces the small internal header that travels in front of it. That header holds a type byte, a length byte, type-dependent data and the receive interface. It is streamed out one byte per cycle. A request is taken while `req_ready_o` is high. The decision appears for one cycle on the next cycle, and the shim bytes follow from that same cycle onward.

Top module: `route_dispatch`

## Requirements
- R1: With no drop, no exception and no special flag, a lookup hit whose transmit interface differs from the receive interface is routed fast path (kind 0, type 0x00). It uses the lookup queue ID and the 4-bit lookup port zero-extended to 8 bits, and emits no shim bytes.
- R2: A hit flagged as destined for a processing engine is routed with kind 1 and type 0x02, using the lookup queue and port. Its shim is: type, length, transmit interface (2 bytes), the 4-byte next-hop address only when next-hop-present is set, and then the receive interface (2 bytes). The length is therefore 10 or 6.
- R3: The drop flag discards the packet: kind 3, type 0x00, queue and port zero, no shim bytes.
- R4: Routing exceptions go to the control engine (kind 2) with these type codes: TTL expired 0x04, IP options 0x05, miss (hit clear) 0x03, and redirect (hit with transmit interface equal to receive interface) 0x06.
- R5: When several causes hold, the highest-ranked one wins, from highest to lowest: drop, invalid forwarding key, TTL, options, miss, local delivery, redirect, inspect, monitor, engine, fast path.
- R6: The other control-engine causes map as follows: local delivery 0x08, inspect 0x07, monitor 0x09, invalid forwarding key 0x0a (log).
- R7: Every control-engine decision carries the configured control queue `CTL_QID` and port `CTL_PORT` in place of the lookup values. Its shim is 6 bytes: type, length 6, transmit interface, receive interface.
- R8: Shim bytes leave most significant byte first, one per cycle, with `shim_valid_o` high. The first byte is the type and the second the total shim length in bytes. `shim_last_o` is high on the final byte only.
- R9: `req_ready_o` is low while shim bytes remain to be sent. A request presented while it is low is ignored and produces no decision.
- R10: The decision outputs are valid for exactly one cycle, the cycle after the accepting clock edge. The first shim byte appears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| hit_i | input | 1 | Lookup found a route |
| drop_i | input | 1 | Lookup says discard |
| nh_present_i | input | 1 | Next-hop address forms part of the forwarding key |
| local_dlv_i | input | 1 | Packet is for local delivery |
| to_engine_i | input | 1 | Next hop is a processing engine |
| inspect_i | input | 1 | Send copy to control for inspection |
| monitor_i | input | 1 | Send to control for monitoring |
| key_err_i | input | 1 | Supplied forwarding key was invalid |
| exc_ttl_i | input | 1 | Parser: TTL is 0 or 1 |
| exc_opt_i | input | 1 | Parser: IP options present |
| out_port_i | input | 4 | Lookup output port |
| qid_i | input | 20 | Lookup queue ID |
| tx_if_i | input | 16 | Transmit interface |
| nh_addr_i | input | 32 | Next-hop address |
| rx_if_i | input | 16 | Receive interface |
| dec_valid_o | output | 1 | Decision valid (one cycle) |
| dec_kind_o | output | 2 | 0 fast, 1 engine, 2 control, 3 drop |
| dec_type_o | output | 8 | Internal header type code |
| dec_qid_o | output | 20 | Chosen queue ID |
| dec_port_o | output | 8 | Chosen output port |
| shim_valid_o | output | 1 | Shim byte valid |
| shim_byte_o | output | 8 | Shim byte |
| shim_last_o | output | 1 | Final shim byte |

## Verification
The bench builds the block with `CTL_QID` = 0xFFFFE and `CTL_PORT` = 0xC3. Both sit well away from any lookup value the bench applies. The upper nibble of 0xC3 cannot come from zero-extending a 4-bit port, so a control decision that leaked the lookup queue or port shows up at once. The interface and next-hop values are chosen with distinct bytes, so any byte-order or length slip in the shim changes a compared byte.

// File: rtl/route_dispatch_pkg.sv
package route_dispatch_pkg;

  typedef enum logic [1:0] {
    KIND_FAST   = 2'd0,
    KIND_ENGINE = 2'd1,
    KIND_CTRL   = 2'd2,
    KIND_DROP   = 2'd3
  } route_kind_e;

  localparam logic [7:0] TY_NONE    = 8'h00;
  localparam logic [7:0] TY_ENGINE  = 8'h02;
  localparam logic [7:0] TY_NOROUTE = 8'h03;
  localparam logic [7:0] TY_TTL     = 8'h04;
  localparam logic [7:0] TY_OPTS    = 8'h05;
  localparam logic [7:0] TY_REDIR   = 8'h06;
  localparam logic [7:0] TY_INSPECT = 8'h07;
  localparam logic [7:0] TY_LOCAL   = 8'h08;
  localparam logic [7:0] TY_MONITOR = 8'h09;
  localparam logic [7:0] TY_LOG     = 8'h0a;

  typedef struct packed {
    logic hit;
    logic drop;
    logic nh_present;
    logic local_dlv;
    logic to_engine;
    logic inspect;
    logic monitor;
    logic key_err;
  } lk_flags_t;

endpackage

// File: rtl/dispatch_classify.sv
module dispatch_classify
  import route_dispatch_pkg::*;
#(
  parameter int IF_W = 16
) (
  input  lk_flags_t         flags_i,
  input  logic              exc_ttl_i,
  input  logic              exc_opt_i,
  input  logic [IF_W-1:0]   tx_if_i,
  input  logic [IF_W-1:0]   rx_if_i,
  output route_kind_e       kind_o,
  output logic [7:0]        type_o
);

  logic same_if;
  assign same_if = (tx_if_i == rx_if_i);

  always_comb begin
    kind_o = KIND_CTRL;
    type_o = TY_NONE;
    if (flags_i.drop) begin
      kind_o = KIND_DROP;
    end else if (flags_i.key_err) begin
      type_o = TY_LOG;
    end else if (exc_ttl_i) begin
      type_o = TY_TTL;
    end else if (exc_opt_i) begin
      type_o = TY_OPTS;
    end else if (!flags_i.hit) begin
      type_o = TY_NOROUTE;
    end else if (flags_i.local_dlv) begin
      type_o = TY_LOCAL;
    end else if (same_if) begin
      type_o = TY_REDIR;
    end else if (flags_i.inspect) begin
      type_o = TY_INSPECT;
    end else if (flags_i.monitor) begin
      type_o = TY_MONITOR;
    end else if (flags_i.to_engine) begin
      kind_o = KIND_ENGINE;
      type_o = TY_ENGINE;
    end else begin
      kind_o = KIND_FAST;
    end
  end

endmodule

// File: rtl/shim_builder.sv
module shim_builder
  import route_dispatch_pkg::*;
#(
  parameter int IF_W = 16,
  parameter int NH_W = 32,
  localparam int IFB    = IF_W / 8,
  localparam int NHB    = NH_W / 8,
  localparam int MAXB   = 2 + 2 * IFB + NHB,
  localparam int SHORTB = 2 + 2 * IFB,
  localparam int SHIM_W = MAXB * 8
) (
  input  route_kind_e         kind_i,
  input  logic [7:0]          type_i,
  input  logic                nh_present_i,
  input  logic [IF_W-1:0]     tx_if_i,
  input  logic [NH_W-1:0]     nh_addr_i,
  input  logic [IF_W-1:0]     rx_if_i,
  output logic [SHIM_W-1:0]   shim_o,
  output logic [7:0]          len_o
);

  logic [SHIM_W-1:0] full_v, short_v;

  assign full_v  = {type_i, 8'(MAXB), tx_if_i, nh_addr_i, rx_if_i};
  assign short_v = {type_i, 8'(SHORTB), tx_if_i, rx_if_i, {NH_W{1'b0}}};

  always_comb begin
    shim_o = '0;
    len_o  = 8'd0;
    if (kind_i == KIND_ENGINE && nh_present_i) begin
      shim_o = full_v;
      len_o  = 8'(MAXB);
    end else if (kind_i == KIND_ENGINE || kind_i == KIND_CTRL) begin
      shim_o = short_v;
      len_o  = 8'(SHORTB);
    end
  end

endmodule

// File: rtl/shim_serializer.sv
module shim_serializer #(
  parameter int MAXB = 10,
  localparam int SHIM_W = MAXB * 8,
  localparam int CNT_W  = $clog2(MAXB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SHIM_W-1:0] shim_i,
  input  logic [7:0]        len_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [7:0]        byte_o,
  output logic              last_o
);

  logic [SHIM_W-1:0] sreg_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      sreg_q <= shim_i;
      cnt_q  <= len_i[CNT_W-1:0];
    end else if (cnt_q != '0) begin
      sreg_q <= sreg_q << 8;
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign valid_o = busy_o;
  assign byte_o  = sreg_q[SHIM_W-1 -: 8];
  assign last_o  = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/route_dispatch.sv
module route_dispatch
  import route_dispatch_pkg::*;
#(
  parameter int               QID_W      = 20,
  parameter int               PORT_IN_W  = 4,
  parameter int               PORT_OUT_W = 8,
  parameter int               IF_W       = 16,
  parameter int               NH_W       = 32,
  parameter logic [QID_W-1:0] CTL_QID    = 20'h00001,
  parameter logic [PORT_OUT_W-1:0] CTL_PORT = 8'h0F,
  localparam int MAXB   = 2 + 2 * (IF_W / 8) + NH_W / 8,
  localparam int SHIM_W = MAXB * 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  hit_i,
  input  logic                  drop_i,
  input  logic                  nh_present_i,
  input  logic                  local_dlv_i,
  input  logic                  to_engine_i,
  input  logic                  inspect_i,
  input  logic                  monitor_i,
  input  logic                  key_err_i,
  input  logic                  exc_ttl_i,
  input  logic                  exc_opt_i,
  input  logic [PORT_IN_W-1:0]  out_port_i,
  input  logic [QID_W-1:0]      qid_i,
  input  logic [IF_W-1:0]       tx_if_i,
  input  logic [NH_W-1:0]       nh_addr_i,
  input  logic [IF_W-1:0]       rx_if_i,
  output logic                  dec_valid_o,
  output logic [1:0]            dec_kind_o,
  output logic [7:0]            dec_type_o,
  output logic [QID_W-1:0]      dec_qid_o,
  output logic [PORT_OUT_W-1:0] dec_port_o,
  output logic                  shim_valid_o,
  output logic [7:0]            shim_byte_o,
  output logic                  shim_last_o
);

  lk_flags_t         flags;
  route_kind_e       kind_d;
  logic [7:0]        type_d;
  logic [SHIM_W-1:0] shim_d;
  logic [7:0]        len_d;
  logic              busy, accept;
  logic [QID_W-1:0]  qid_d;
  logic [PORT_OUT_W-1:0] port_d;

  assign flags = '{hit: hit_i, drop: drop_i, nh_present: nh_present_i,
                   local_dlv: local_dlv_i, to_engine: to_engine_i,
                   inspect: inspect_i, monitor: monitor_i, key_err: key_err_i};

  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;

  dispatch_classify #(.IF_W(IF_W)) u_cls (
    .flags_i   (flags),
    .exc_ttl_i (exc_ttl_i),
    .exc_opt_i (exc_opt_i),
    .tx_if_i   (tx_if_i),
    .rx_if_i   (rx_if_i),
    .kind_o    (kind_d),
    .type_o    (type_d)
  );

  shim_builder #(.IF_W(IF_W), .NH_W(NH_W)) u_bld (
    .kind_i       (kind_d),
    .type_i       (type_d),
    .nh_present_i (nh_present_i),
    .tx_if_i      (tx_if_i),
    .nh_addr_i    (nh_addr_i),
    .rx_if_i      (rx_if_i),
    .shim_o       (shim_d),
    .len_o        (len_d)
  );

  shim_serializer #(.MAXB(MAXB)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shim_i  (shim_d),
    .len_i   (len_d),
    .busy_o  (busy),
    .valid_o (shim_valid_o),
    .byte_o  (shim_byte_o),
    .last_o  (shim_last_o)
  );

  always_comb begin
    unique case (kind_d)
      KIND_FAST, KIND_ENGINE: begin
        qid_d  = qid_i;
        port_d = PORT_OUT_W'(out_port_i);
      end
      KIND_CTRL: begin
        qid_d  = CTL_QID;
        port_d = CTL_PORT;
      end
      default: begin
        qid_d  = '0;
        port_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_kind_o  <= 2'd0;
      dec_type_o  <= 8'd0;
      dec_qid_o   <= '0;
      dec_port_o  <= '0;
    end else begin
      dec_valid_o <= accept;
      if (accept) begin
        dec_kind_o <= kind_d;
        dec_type_o <= type_d;
        dec_qid_o  <= qid_d;
        dec_port_o <= port_d;
      end
    end
  end

endmodule

// File: rtl/route_dispatch_checker.sv
module route_dispatch_checker #(
  parameter int QID_W      = 20,
  parameter int PORT_OUT_W = 8,
  parameter int IF_W       = 16,
  parameter int NH_W       = 32,
  parameter logic [QID_W-1:0]      CTL_QID  = 20'h00001,
  parameter logic [PORT_OUT_W-1:0] CTL_PORT = 8'h0F
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_ready_o,
  input logic                  dec_valid_o,
  input logic [1:0]            dec_kind_o,
  input logic [7:0]            dec_type_o,
  input logic [QID_W-1:0]      dec_qid_o,
  input logic [PORT_OUT_W-1:0] dec_port_o,
  input logic                  shim_valid_o,
  input logic [7:0]            shim_byte_o,
  input logic                  shim_last_o
);

  localparam int SHORTB = 2 + 2 * (IF_W / 8);
  localparam int MAXB   = SHORTB + NH_W / 8;

  AST_NO_REQ_WHILE_SHIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shim_valid_o |-> !req_ready_o); // R9
  AST_FAST_NO_SHIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_kind_o == 2'd0 |-> !shim_valid_o && dec_type_o == 8'h00); // R1
  AST_DROP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_kind_o == 2'd3 |-> !shim_valid_o && dec_qid_o == '0); // R3
  AST_CTRL_QUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_kind_o == 2'd2 |-> dec_qid_o == CTL_QID && dec_port_o == CTL_PORT); // R7
  AST_CTRL_TYPE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_kind_o == 2'd2 |-> dec_type_o >= 8'h03 && dec_type_o <= 8'h0a); // R4
  AST_FIRST_BYTE_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && shim_valid_o |-> shim_byte_o == dec_type_o); // R8
  AST_LEN_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && shim_valid_o |=> shim_valid_o &&
      (shim_byte_o == 8'(SHORTB) || shim_byte_o == 8'(MAXB))); // R8
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shim_last_o |=> !shim_valid_o); // R8
  AST_DEC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && shim_valid_o |=> !dec_valid_o); // R10

endmodule

bind route_dispatch route_dispatch_checker #(
  .QID_W(QID_W), .PORT_OUT_W(PORT_OUT_W), .IF_W(IF_W), .NH_W(NH_W),
  .CTL_QID(CTL_QID), .CTL_PORT(CTL_PORT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .dec_valid_o(dec_valid_o), .dec_kind_o(dec_kind_o), .dec_type_o(dec_type_o),
  .dec_qid_o(dec_qid_o), .dec_port_o(dec_port_o), .shim_valid_o(shim_valid_o),
  .shim_byte_o(shim_byte_o), .shim_last_o(shim_last_o)
);

// File: tb/tb_route_dispatch.sv
module tb_route_dispatch;

  localparam logic [19:0] CQ = 20'hFFFFE;
  localparam logic [7:0]  CP = 8'hC3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid, hit, drop, nhp, loc, eng, insp, mon, kerr, ttl, opt;
  logic [3:0]  oport;
  logic [19:0] qid;
  logic [15:0] txif, rxif;
  logic [31:0] nh;
  logic req_ready, dvalid, svalid, slast;
  logic [1:0]  dkind;
  logic [7:0]  dtype, dport, sbyte;
  logic [19:0] dqid;

  route_dispatch #(.CTL_QID(CQ), .CTL_PORT(CP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .hit_i(hit), .drop_i(drop), .nh_present_i(nhp), .local_dlv_i(loc),
    .to_engine_i(eng), .inspect_i(insp), .monitor_i(mon), .key_err_i(kerr),
    .exc_ttl_i(ttl), .exc_opt_i(opt), .out_port_i(oport), .qid_i(qid),
    .tx_if_i(txif), .nh_addr_i(nh), .rx_if_i(rxif), .dec_valid_o(dvalid),
    .dec_kind_o(dkind), .dec_type_o(dtype), .dec_qid_o(dqid), .dec_port_o(dport),
    .shim_valid_o(svalid), .shim_byte_o(sbyte), .shim_last_o(slast));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input logic ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // expected model, written from the requirements
  logic [1:0]  e_kind;
  logic [7:0]  e_type, e_port;
  logic [19:0] e_qid;
  logic [7:0]  e_b [10];
  int          e_n;

  task automatic model();
    e_kind = 2'd2; e_type = 8'h00;
    if (drop) e_kind = 2'd3;
    else if (kerr) e_type = 8'h0a;
    else if (ttl) e_type = 8'h04;
    else if (opt) e_type = 8'h05;
    else if (!hit) e_type = 8'h03;
    else if (loc) e_type = 8'h08;
    else if (txif == rxif) e_type = 8'h06;
    else if (insp) e_type = 8'h07;
    else if (mon) e_type = 8'h09;
    else if (eng) begin e_kind = 2'd1; e_type = 8'h02; end
    else e_kind = 2'd0;
    case (e_kind)
      2'd0, 2'd1: begin e_qid = qid; e_port = {4'h0, oport}; end
      2'd2: begin e_qid = CQ; e_port = CP; end
      default: begin e_qid = '0; e_port = '0; end
    endcase
    e_n = 0;
    if (e_kind == 2'd1 || e_kind == 2'd2) begin
      e_b[0] = e_type;
      e_b[2] = txif[15:8]; e_b[3] = txif[7:0];
      if (e_kind == 2'd1 && nhp) begin
        e_b[4] = nh[31:24]; e_b[5] = nh[23:16]; e_b[6] = nh[15:8]; e_b[7] = nh[7:0];
        e_b[8] = rxif[15:8]; e_b[9] = rxif[7:0]; e_n = 10;
      end else begin
        e_b[4] = rxif[15:8]; e_b[5] = rxif[7:0]; e_n = 6;
      end
      e_b[1] = 8'(e_n);
    end
  endtask

  task automatic clear_in();
    req_valid = 0; hit = 0; drop = 0; nhp = 0; loc = 0; eng = 0; insp = 0;
    mon = 0; kerr = 0; ttl = 0; opt = 0; oport = 4'h0; qid = '0;
    txif = 16'h1122; rxif = 16'h3344; nh = 32'hA1B2C3D4;
  endtask

  // inputs are already set; pulse valid, then check decision and shim
  task automatic apply_and_check(input string tag);
    @(negedge clk);
    chk(req_ready, tag, "ready before request", req_ready, 1);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    model();
    chk(dvalid == 1, tag, "dec_valid", dvalid, 1);
    chk(dkind == e_kind, tag, "kind", dkind, e_kind);
    chk(dtype == e_type, tag, "type", dtype, e_type);
    chk(dqid == e_qid, tag, "qid", dqid, e_qid);
    chk(dport == e_port, tag, "port", dport, e_port);
    for (int i = 0; i < e_n; i++) begin
      chk(svalid == 1, "R8", $sformatf("%s byte%0d valid", tag, i), svalid, 1);
      chk(sbyte == e_b[i], "R8", $sformatf("%s byte%0d", tag, i), sbyte, e_b[i]);
      chk(slast == (i == e_n - 1), "R8", $sformatf("%s last%0d", tag, i), slast, i == e_n - 1);
      if (i > 0) chk(dvalid == 0, "R10", "dec pulse width", dvalid, 0);
      @(negedge clk);
    end
    if (e_n == 0) begin
      chk(svalid == 0, tag, "no shim", svalid, 0);
      @(negedge clk);
    end
    chk(dvalid == 0, "R10", $sformatf("%s dec drops", tag), dvalid, 0);
    chk(svalid == 0, tag, "shim ended", svalid, 0);
    chk(req_ready == 1, "R9", $sformatf("%s ready back", tag), req_ready, 1);
    clear_in();
  endtask

  task automatic t_reset();
    chk(dvalid == 0, "R10", "reset dec_valid", dvalid, 0);
    chk(svalid == 0, "R8", "reset shim_valid", svalid, 0);
    chk(req_ready == 1, "R9", "reset ready", req_ready, 1);
  endtask

  task automatic t_fast();
    hit = 1; oport = 4'hB; qid = 20'h12345; apply_and_check("R1");
  endtask

  task automatic t_engine_short();
    hit = 1; eng = 1; oport = 4'h5; qid = 20'h0ABCD; apply_and_check("R2");
  endtask

  task automatic t_engine_nh();
    hit = 1; eng = 1; nhp = 1; oport = 4'h7; qid = 20'h54321;
    txif = 16'h5A6B; rxif = 16'h7C8D; nh = 32'h0F1E2D3C; apply_and_check("R2");
  endtask

  task automatic t_drop_all();
    hit = 0; drop = 1; kerr = 1; ttl = 1; opt = 1; loc = 1; eng = 1; qid = 20'h77777;
    oport = 4'h3; apply_and_check("R3");
  endtask

  task automatic t_key_err();
    hit = 1; kerr = 1; ttl = 1; eng = 1; apply_and_check("R6");
  endtask

  task automatic t_prio_ttl();
    hit = 0; ttl = 1; opt = 1; loc = 1; apply_and_check("R5");
  endtask

  task automatic t_opts();
    hit = 0; opt = 1; loc = 1; apply_and_check("R4");
  endtask

  task automatic t_noroute();
    hit = 0; loc = 1; eng = 1; qid = 20'h00042; apply_and_check("R4");
  endtask

  task automatic t_local();
    hit = 1; loc = 1; txif = 16'h4242; rxif = 16'h4242; apply_and_check("R6");
  endtask

  task automatic t_redirect();
    hit = 1; eng = 1; insp = 1; txif = 16'h0909; rxif = 16'h0909; apply_and_check("R4");
  endtask

  task automatic t_inspect();
    hit = 1; insp = 1; mon = 1; eng = 1; apply_and_check("R6");
  endtask

  task automatic t_monitor();
    hit = 1; mon = 1; eng = 1; oport = 4'hF; apply_and_check("R7");
  endtask

  task automatic t_busy_ignore();
    int pulses;
    hit = 1; eng = 1; nhp = 1; qid = 20'h0BEEF;
    @(negedge clk); req_valid = 1;
    @(negedge clk);
    // first shim byte is out; present a drop request while busy
    chk(req_ready == 0, "R9", "ready low while shim", req_ready, 0);
    drop = 1; req_valid = 1;
    @(negedge clk); req_valid = 0;
    pulses = 0;
    for (int i = 0; i < 14; i++) begin
      if (dvalid) pulses++;
      @(negedge clk);
    end
    chk(pulses == 0, "R9", "ignored request decisions", pulses, 0);
    chk(req_ready == 1, "R9", "ready after shim", req_ready, 1);
    clear_in();
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_fast();
    t_engine_short();
    t_engine_nh();
    t_drop_all();
    t_key_err();
    t_prio_ttl();
    t_opts();
    t_noroute();
    t_local();
    t_redirect();
    t_inspect();
    t_monitor();
    t_busy_ignore();
    t_fast();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule